// File: doc/BRIEF.md
# PWM Duty Detector with Direction-Dependent Hysteresis

This block turns a pulse-width-modulated control pin into an 11-bit brightness fraction. The pin is synchronized, optionally inverted, and sampled on one of two externally supplied sample-enable pulse trains: a slow one and a fast one. One period runs from a rising edge of the active level to the next rising edge. Within that span the block counts the samples at the active level and the total samples. A shared sequential divider then forms `floor(high * 2047 / period)`.

A hysteresis filter sits between the divider and the output. After a change of direction, and after the first value, a new result must move away from the held value by a selectable number of LSBs before it is adopted. While the movement keeps the same direction, every new result is adopted at once.

A timeout counter handles the case of a pin that stops toggling. If the pin stays high too long, the block reports full scale. If it stays low too long, the block flags that the backlight is off.

Top module: `pwm_duty_detector`

## Requirements
- R1: For each complete period of H active samples and L inactive samples, the block reports `duty_o = floor(H*2047/(H+L))`, provided H and L are both at least MIN_PULSE (6).
- R2: When `pol_i`=1 the active level is pin low, and rising edges of the inverted signal delimit the period. When `pol_i`=0 the pin is taken as it is.
- R3: When `rate_i`=0, counting uses `tick_slow_i` and ignores `tick_fast_i`. When `rate_i`=1, counting uses `tick_fast_i`.
- R4: After `en_i` rises, the period in progress is ignored. No result (`valid_o` stays low, `duty_o` stays 0) appears before two rising edges have been sampled.
- R5: A period with fewer than MIN_PULSE active samples, or fewer than MIN_PULSE inactive samples, is discarded. It produces no `valid_o` pulse and leaves `duty_o` unchanged.
- R6: If the active level persists for the timeout length (TO_FAST samples at `rate_i`=1, TO_SLOW samples at `rate_i`=0) since the last rising edge, `duty_o` becomes 2047 with one `valid_o` pulse and `off_o`=0. The block then again needs two edges before it measures.
- R7: If the inactive level persists for the timeout length, `off_o` goes to 1 with `duty_o`=0. After a full-scale timeout, a falling edge restarts the timeout count. The next published measurement clears `off_o`.
- R8: `hyst_sel_i` 0, 1, 2 and 3 set a hysteresis of 1, 2, 4 and 6 LSBs.
- R9: The first result after enable, or after an off timeout, is taken directly. After that, a result moving opposite to the last adopted direction, or moving at all right after a full-scale timeout, is adopted only if it differs from the held value by at least the hysteresis. A result moving in the same direction is always adopted.
- R10: While `en_i`=0, from the next clock on, `duty_o`=0, `off_o`=0 and `valid_o`=0, and all measurement state is cleared.
- R11: `valid_o` is a single-cycle pulse, issued once per measurement that is not discarded and once per timeout. `duty_o` changes only in a cycle with `valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detector enable; low clears all state |
| pwm_i | input | 1 | Raw PWM pin, asynchronous |
| pol_i | input | 1 | 0: active high, 1: active low |
| rate_i | input | 1 | 0: slow sample train, 1: fast sample train |
| hyst_sel_i | input | 2 | Hysteresis select (1/2/4/6 LSB) |
| tick_slow_i | input | 1 | Slow sample-enable pulse |
| tick_fast_i | input | 1 | Fast sample-enable pulse |
| duty_o | output | 11 | Filtered duty fraction, 2047 = full |
| valid_o | output | 1 | Pulse when a result or timeout is published |
| off_o | output | 1 | Backlight-off indication from a low timeout |

## Verification
The hardest case to reach from the ports is a direction reversal whose size lies between two hysteresis settings. Reaching it needs 1-LSB control over the measured value. The stimulus uses a period of exactly 2047 samples, so the measured duty equals the active-sample count. It then replays one fixed sequence of small rises and falls under every hysteresis setting and compares each held value against an arithmetic model. The timeout paths are reached by holding the pin past the limit, which is shortened through parameters: first high, then low without any intervening rising edge.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;
  localparam int DUTY_W = 11;
  localparam logic [DUTY_W-1:0] DUTY_FULL = '1;

  typedef enum logic [1:0] {DIR_NONE, DIR_UP, DIR_DOWN} dir_e;

  function automatic logic [2:0] hyst_lsb(input logic [1:0] sel);
    case (sel)
      2'd0: hyst_lsb = 3'd1;
      2'd1: hyst_lsb = 3'd2;
      2'd2: hyst_lsb = 3'd4;
      default: hyst_lsb = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/pwm_in_sync.sv
module pwm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic level_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], pin_i};
  end

  assign level_o = sync_q[STAGES-1] ^ pol_i;
endmodule

// File: rtl/pwm_period_meter.sv
module pwm_period_meter #(
  parameter int CNT_W     = 15,
  parameter int MIN_PULSE = 6,
  parameter int TO_SLOW   = 25000,
  parameter int TO_FAST   = 12000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             rate_i,
  input  logic             level_i,
  output logic             meas_o,
  output logic [CNT_W-1:0] high_o,
  output logic [CNT_W-1:0] period_o,
  output logic             to_high_o,
  output logic             to_low_o
);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PULSE);

  logic primed_q, prev_q, armed_q, timed_out_q;
  logic [CNT_W-1:0] high_q, per_q, idle_q;
  logic [CNT_W-1:0] limit;
  logic rise, fall, wide_ok;

  assign limit   = rate_i ? CNT_W'(TO_FAST) : CNT_W'(TO_SLOW);
  assign rise    = primed_q & level_i & ~prev_q;
  assign fall    = primed_q & ~level_i & prev_q;
  assign wide_ok = (high_q >= MIN_C) && ((per_q - high_q) >= MIN_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0; prev_q <= 1'b0; armed_q <= 1'b0; timed_out_q <= 1'b0;
      high_q <= '0; per_q <= '0; idle_q <= '0;
      meas_o <= 1'b0; high_o <= '0; period_o <= '0;
      to_high_o <= 1'b0; to_low_o <= 1'b0;
    end else if (!en_i) begin
      primed_q <= 1'b0; prev_q <= 1'b0; armed_q <= 1'b0; timed_out_q <= 1'b0;
      high_q <= '0; per_q <= '0; idle_q <= '0;
      meas_o <= 1'b0; high_o <= '0; period_o <= '0;
      to_high_o <= 1'b0; to_low_o <= 1'b0;
    end else begin
      meas_o    <= 1'b0;
      to_high_o <= 1'b0;
      to_low_o  <= 1'b0;
      if (tick_i) begin
        primed_q <= 1'b1;
        prev_q   <= level_i;
        if (rise) begin
          if (armed_q && wide_ok) begin
            meas_o   <= 1'b1;
            high_o   <= high_q;
            period_o <= per_q;
          end
          armed_q     <= 1'b1;
          high_q      <= CNT_W'(1);
          per_q       <= CNT_W'(1);
          idle_q      <= CNT_W'(1);
          timed_out_q <= 1'b0;
        end else begin
          if (armed_q) begin
            per_q  <= per_q + CNT_W'(1);
            high_q <= high_q + CNT_W'(level_i);
          end
          // a fall after full-scale timeout restarts the off timer
          if (fall && timed_out_q) begin
            idle_q      <= CNT_W'(1);
            timed_out_q <= 1'b0;
          end else if (!timed_out_q) begin
            if (idle_q >= limit - CNT_W'(1)) begin
              timed_out_q <= 1'b1;
              armed_q     <= 1'b0;
              to_high_o   <= level_i;
              to_low_o    <= ~level_i;
            end else begin
              idle_q <= idle_q + CNT_W'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_duty_div.sv
module pwm_duty_div
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  high_i,
  input  logic [CNT_W-1:0]  period_i,
  output logic              done_o,
  output logic [DUTY_W-1:0] quot_o
);
  localparam int NUM_W = CNT_W + DUTY_W;
  localparam int IDX_W = $clog2(DUTY_W);

  logic [NUM_W-1:0]  rem_q, num, den_sh;
  logic [CNT_W-1:0]  den_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic [DUTY_W-1:0] q_q;

  assign num    = {high_i, {DUTY_W{1'b0}}} - NUM_W'(high_i);
  assign den_sh = NUM_W'(den_q) << idx_q;
  assign quot_o = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; den_q <= '0; idx_q <= '0; busy_q <= 1'b0; q_q <= '0; done_o <= 1'b0;
    end else if (clr_i) begin
      rem_q <= '0; den_q <= '0; idx_q <= '0; busy_q <= 1'b0; q_q <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= num;
        den_q  <= period_i;
        idx_q  <= IDX_W'(DUTY_W - 1);
        busy_q <= 1'b1;
        q_q    <= '0;
      end else if (busy_q) begin
        if (rem_q >= den_sh) begin
          rem_q      <= rem_q - den_sh;
          q_q[idx_q] <= 1'b1;
        end
        if (idx_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          idx_q <= idx_q - IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_hyst_filter.sv
module pwm_hyst_filter
  import pwm_duty_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        hyst_sel_i,
  input  logic              new_i,
  input  logic [DUTY_W-1:0] new_val_i,
  input  logic              to_high_i,
  input  logic              to_low_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              valid_o,
  output logic              off_o
);
  logic [DUTY_W-1:0] held_q, up_diff, dn_diff, amt;
  logic              have_q;
  dir_e              dir_q;

  assign amt     = DUTY_W'(hyst_lsb(hyst_sel_i));
  assign up_diff = new_val_i - held_q;
  assign dn_diff = held_q - new_val_i;
  assign duty_o  = held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0; have_q <= 1'b0; dir_q <= DIR_NONE; valid_o <= 1'b0; off_o <= 1'b0;
    end else if (!en_i) begin
      held_q <= '0; have_q <= 1'b0; dir_q <= DIR_NONE; valid_o <= 1'b0; off_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (to_high_i) begin
        held_q <= DUTY_FULL; have_q <= 1'b1; dir_q <= DIR_NONE;
        off_o <= 1'b0; valid_o <= 1'b1;
      end else if (to_low_i) begin
        held_q <= '0; have_q <= 1'b0; dir_q <= DIR_NONE;
        off_o <= 1'b1; valid_o <= 1'b1;
      end else if (new_i) begin
        valid_o <= 1'b1;
        off_o   <= 1'b0;
        if (!have_q) begin
          held_q <= new_val_i;
          have_q <= 1'b1;
        end else if (new_val_i > held_q) begin
          if (dir_q == DIR_UP || up_diff >= amt) begin
            held_q <= new_val_i;
            dir_q  <= DIR_UP;
          end
        end else if (new_val_i < held_q) begin
          if (dir_q == DIR_DOWN || dn_diff >= amt) begin
            held_q <= new_val_i;
            dir_q  <= DIR_DOWN;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_duty_detector.sv
module pwm_duty_detector
  import pwm_duty_pkg::*;
#(
  parameter int TO_SLOW   = 25000,
  parameter int TO_FAST   = 12000,
  parameter int MIN_PULSE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pwm_i,
  input  logic              pol_i,
  input  logic              rate_i,
  input  logic [1:0]        hyst_sel_i,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              valid_o,
  output logic              off_o
);
  localparam int TO_MAX = (TO_SLOW > TO_FAST) ? TO_SLOW : TO_FAST;
  localparam int CNT_W  = $clog2(TO_MAX + 1);

  logic              level, tick, meas, to_high, to_low, div_done;
  logic [CNT_W-1:0]  high_cnt, per_cnt;
  logic [DUTY_W-1:0] quot;

  assign tick = rate_i ? tick_fast_i : tick_slow_i;

  pwm_in_sync #(.STAGES(2)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pwm_i), .pol_i(pol_i), .level_o(level)
  );

  pwm_period_meter #(
    .CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE), .TO_SLOW(TO_SLOW), .TO_FAST(TO_FAST)
  ) i_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick), .rate_i(rate_i),
    .level_i(level), .meas_o(meas), .high_o(high_cnt), .period_o(per_cnt),
    .to_high_o(to_high), .to_low_o(to_low)
  );

  pwm_duty_div #(.CNT_W(CNT_W)) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(~en_i), .start_i(meas),
    .high_i(high_cnt), .period_i(per_cnt), .done_o(div_done), .quot_o(quot)
  );

  pwm_hyst_filter i_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hyst_sel_i(hyst_sel_i),
    .new_i(div_done), .new_val_i(quot), .to_high_i(to_high), .to_low_i(to_low),
    .duty_o(duty_o), .valid_o(valid_o), .off_o(off_o)
  );
endmodule

// File: rtl/pwm_duty_detector_chk.sv
module pwm_duty_detector_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic [10:0] duty_o,
  input logic        valid_o,
  input logic        off_o
);
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (duty_o == 11'd0 && !off_o && !valid_o)); // R10
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R11
  AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !valid_o) |-> $stable(duty_o)); // R11
  AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o |-> duty_o == 11'd0); // R7
  AST_OFF_RISE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(off_o) |-> valid_o); // R7
endmodule

bind pwm_duty_detector pwm_duty_detector_chk i_chk (.*);

// File: tb/test_pwm_duty_detector.sv
module test_pwm_duty_detector;
  localparam int TO_SLOW = 1500;
  localparam int TO_FAST = 4000;
  localparam int MINP    = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, pwm_i = 1'b0, pol_i = 1'b0, rate_i = 1'b1;
  logic [1:0]  hyst_sel_i = 2'd0;
  logic        tick_slow_i = 1'b0;
  logic        tick_fast_i = 1'b1;
  logic [10:0] duty_o;
  logic        valid_o, off_o;

  int checks = 0, errors = 0, vcount = 0, vexp = 0;
  int m_held = 0, m_have = 0, m_dir = 0, m_off = 0;
  int pend_h = 0, pend_l = 0, pend_v = 0;
  logic [1:0] slow_cnt = 2'd0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    slow_cnt    <= slow_cnt + 2'd1;
    tick_slow_i <= (slow_cnt == 2'd3);
  end

  always @(negedge clk_i) if (valid_o) vcount++;

  pwm_duty_detector #(.TO_SLOW(TO_SLOW), .TO_FAST(TO_FAST), .MIN_PULSE(MINP)) i_pwm_duty_detector (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pwm_i(pwm_i), .pol_i(pol_i),
    .rate_i(rate_i), .hyst_sel_i(hyst_sel_i), .tick_slow_i(tick_slow_i),
    .tick_fast_i(tick_fast_i), .duty_o(duty_o), .valid_o(valid_o), .off_o(off_o)
  );

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int hyst_amt(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 2 : (sel == 2) ? 4 : 6;
  endfunction

  function automatic void model_apply(int h, int l);
    int v;
    if (h < MINP || l < MINP) return;
    v = h * 2047 / (h + l);
    vexp++;
    m_off = 0;
    if (m_have == 0) begin
      m_held = v; m_have = 1;
    end else if (v > m_held) begin
      if (m_dir == 1 || v - m_held >= hyst_amt(hyst_sel_i)) begin m_held = v; m_dir = 1; end
    end else if (v < m_held) begin
      if (m_dir == 2 || m_held - v >= hyst_amt(hyst_sel_i)) begin m_held = v; m_dir = 2; end
    end
  endfunction

  task automatic drive(bit act);
    pwm_i = act ^ pol_i;
  endtask

  // one period: rising edge (closes the pending period), H active, L inactive
  task automatic pulse(int h, int l, int u, string req);
    bit applied;
    drive(1'b1);
    applied = pend_v[0];
    if (pend_v != 0) model_apply(pend_h, pend_l);
    repeat (h * u) @(negedge clk_i);
    drive(1'b0);
    repeat (l * u) @(negedge clk_i);
    pend_h = h; pend_l = l; pend_v = 1;
    if (applied && (h + l) * u >= 24) begin
      check_eq(req, duty_o, m_held);
      check_eq(req, off_o, m_off);
    end
  endtask

  task automatic restart(int sel, bit pol, bit rate);
    en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check_eq("R10 duty", duty_o, 0);
    check_eq("R10 off", off_o, 0);
    check_eq("R10 valid", valid_o, 0);
    hyst_sel_i = 2'(sel); pol_i = pol; rate_i = rate;
    drive(1'b0);
    m_held = 0; m_have = 0; m_dir = 0; m_off = 0; pend_v = 0;
    repeat (4) @(negedge clk_i);
    en_i = 1'b1;
    repeat (20) @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0;
    int hl[9] = '{1000, 1001, 1003, 1006, 1007, 1005, 1002, 1001, 1008};
    repeat (5) @(negedge clk_i);
    check_eq("R10 reset duty", duty_o, 0);
    check_eq("R10 reset valid", valid_o, 0);
    rst_ni = 1'b1;
    restart(0, 1'b0, 1'b1);

    // R4: one edge only, nothing published
    v0 = vcount;
    pulse(20, 44, 1, "R4");
    check_eq("R4 no valid", vcount - v0, 0);
    check_eq("R4 duty", duty_o, 0);

    // R1 sweep of active width over a 64-sample period
    for (int h = 6; h <= 58; h++) pulse(h, 64 - h, 1, "R1");
    pulse(30, 34, 1, "R1");
    check_eq("R11 valid count", vcount, vexp);

    // R5 short active and short inactive widths are dropped
    v0 = vcount;
    pulse(3, 61, 1, "R5");
    pulse(30, 34, 1, "R5 short high");
    check_eq("R5 no valid", vcount - v0, 1);
    pulse(60, 4, 1, "R5");
    pulse(40, 24, 1, "R5 short low");
    pulse(40, 24, 1, "R5");
    check_eq("R11 valid count", vcount, vexp);

    // R2 inverted polarity
    restart(0, 1'b1, 1'b1);
    pulse(10, 30, 1, "R2");
    for (int h = 8; h <= 32; h += 6) pulse(h, 40 - h, 1, "R2");
    pulse(20, 20, 1, "R2");

    // R3 slow sample train, units of four clocks
    restart(0, 1'b0, 1'b0);
    pulse(10, 22, 4, "R3");
    for (int h = 7; h <= 25; h += 3) pulse(h, 32 - h, 4, "R3");
    pulse(12, 20, 4, "R3");

    // R8 R9 hysteresis with 1-LSB resolution (period 2047)
    for (int s = 0; s < 4; s++) begin
      restart(s, 1'b0, 1'b1);
      for (int k = 0; k < 9; k++) pulse(hl[k], 2047 - hl[k], 1, "R8 R9");
      pulse(1000, 1047, 1, "R8 R9");
    end

    // R6 full-scale timeout
    restart(1, 1'b0, 1'b1);
    pulse(30, 34, 1, "R6");
    pulse(20, 44, 1, "R6");
    drive(1'b1);
    model_apply(pend_h, pend_l);
    pend_v = 0;
    repeat (3900) @(negedge clk_i);
    check_eq("R6 before timeout", duty_o, m_held);
    repeat (200) @(negedge clk_i);
    m_held = 2047; m_have = 1; m_dir = 0; m_off = 0; vexp++;
    check_eq("R6 duty", duty_o, 2047);
    check_eq("R6 off", off_o, 0);

    // R7 off timeout after a fall, then recovery
    drive(1'b0);
    repeat (4100) @(negedge clk_i);
    m_held = 0; m_have = 0; m_off = 1; vexp++;
    check_eq("R7 duty", duty_o, 0);
    check_eq("R7 off", off_o, 1);
    pulse(30, 34, 1, "R7");
    check_eq("R7 still off", off_o, 1);
    pulse(30, 34, 1, "R7 cleared");
    check_eq("R11 valid count", vcount, vexp);

    // R10 disable mid-run
    en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check_eq("R10 duty", duty_o, 0);
    check_eq("R10 off", off_o, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule